// File: doc/BRIEF.md
# Data-Strobe Delay Window Trainer

This block trains the delay setting of a data-strobe delay line. On a start pulse it sweeps an 8-bit setting upward from zero. It drives each setting to the delay line in Gray code, so neighbouring steps differ in a single bit. At every step it runs a short write/readback test through a word-wide memory request port. Six test words are first cleared, then filled with rotating patterns, then read back and compared.

The first setting whose test passes is the lower edge of the working window. The sweep then continues from the setting just above it, in a separate address region, until a test fails. That failing setting is the upper edge. The trainer programs the setting two thirds of the way from the lower edge towards the upper edge. If no setting from 0 to 254 passes, it writes a fixed fallback code instead. The delay line and the memory controller sit outside the block.

Top module: `dqs_window_trainer`

## Requirements
- R1: A start pulse while idle sets busy and clears done on the next cycle. At completion, busy falls and done rises on the same edge, and done stays high until the next start. A start pulse while busy has no effect on the run. Reset returns busy, done, found, mem_req and dly_code to zero.
- R2: During a sweep, dly_code carries setting s as s XOR (s >> 1). The first step uses setting 0, and successive sweep values differ in exactly one bit.
- R3: A step issues six writes of zero, then six writes of the patterns 0x12345678, 0x81234567, 0x78123456, 0x67812345, 0x56781234, 0x45678123 (word k holds 0x12345678 rotated right by 4k bits), then reads the words back in order. The step fails at the first read that differs from its pattern, and no further access of that step is issued.
- R4: Test word k (k = 0..5) sits at base + k × 0x100. When dual_rank is high, rank_base is added for odd k (the second, fourth and sixth words).
- R5: The lower-edge search uses base 0x4000. low_bound is the first setting at which all six words match.
- R6: The upper-edge search uses base 0x8000 and starts at low_bound + 1. high_bound is the first failing setting up to 254, or 255 if none fails; a lower edge of 254 gives 255 with no further test.
- R7: On success, final_setting = low + ((high − low) × 2) / 3 with integer division. dly_code ends at the Gray code of that value, and found is 1.
- R8: If no setting from 0 to 254 passes, dly_code and final_setting end at 0x59 (written as is, not Gray coded), found is 0, and both bounds read 255.
- R9: Only one access is outstanding at a time. mem_req and its address, write flag and data stay unchanged until mem_ack, and mem_req is low in the cycle after the ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (ignored while busy) |
| dual_rank | input | 1 | Two ranks present; odd test words go to the second rank |
| rank_base | input | AW | Address offset of the second rank |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | DW | Read data |
| dly_code | output | SW | Delay setting driven to the delay line |
| busy | output | 1 | Training run in progress |
| done | output | 1 | Run finished; results valid |
| found | output | 1 | A passing window was found |
| low_bound | output | SW | First passing setting |
| high_bound | output | SW | First failing setting above the lower edge |
| final_setting | output | SW | Programmed setting, in binary |

## Verification
The checker takes for granted that mem_ack is raised only while mem_req is high, once per request, with read data valid in that cycle. It also assumes dual_rank and rank_base stay still for a whole run. The bench memory model keeps to this. It watches for requests at the falling edge, waits a per-vector latency of zero to three cycles, acknowledges for exactly one cycle, and changes rank settings only between runs. The model decides pass or fail from the setting it decodes off dly_code. In a failing step, every read returns corrupted data, so the bench can predict the exact number of accesses for each window.

// File: rtl/dqscal_pkg.sv
`timescale 1ns/1ps
package dqscal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_ISSUE,
    ST_WAIT,
    ST_FINAL
  } state_t;

  typedef enum logic [1:0] {
    PH_CLR,
    PH_FILL,
    PH_CHK
  } phase_t;

endpackage

// File: rtl/dqscal_gray.sv
`timescale 1ns/1ps
module dqscal_gray #(
  parameter int W = 8
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == W - 1) begin : g_msb
      assign gray_o[b] = bin_i[b];
    end else begin : g_low
      assign gray_o[b] = bin_i[b] ^ bin_i[b+1];
    end
  end

endmodule

// File: rtl/dqscal_access_gen.sv
`timescale 1ns/1ps
module dqscal_access_gen
  import dqscal_pkg::*;
#(
  parameter int              AW        = 32,
  parameter int              DW        = 32,
  parameter int              WIDX      = 3,
  parameter int              STRIDE_SH = 8,
  parameter logic [AW-1:0]   LOW_BASE  = 'h4000,
  parameter logic [AW-1:0]   HIGH_BASE = 'h8000,
  parameter logic [DW-1:0]   SEED      = 'h12345678
) (
  input  phase_t          phase_i,
  input  logic [WIDX-1:0] word_i,
  input  logic            hi_region_i,
  input  logic            dual_rank_i,
  input  logic [AW-1:0]   rank_base_i,
  output logic [AW-1:0]   addr_o,
  output logic            we_o,
  output logic [DW-1:0]   wdata_o,
  output logic [DW-1:0]   expect_o
);

  localparam logic [2*DW-1:0] SEED2 = {SEED, SEED};

  logic [2*DW-1:0] rot;
  logic [DW-1:0]   pattern;
  logic [AW-1:0]   base;
  logic [AW-1:0]   rank_off;

  always_comb begin
    rot      = SEED2 >> (4 * int'(word_i));
    pattern  = rot[DW-1:0];
    base     = hi_region_i ? HIGH_BASE : LOW_BASE;
    rank_off = (dual_rank_i && word_i[0]) ? rank_base_i : '0;
    addr_o   = base + (AW'(word_i) << STRIDE_SH) + rank_off;
    we_o     = (phase_i != PH_CHK);
    wdata_o  = (phase_i == PH_CLR) ? '0 : pattern;
    expect_o = pattern;
  end

endmodule

// File: rtl/dqscal_window_calc.sv
`timescale 1ns/1ps
module dqscal_window_calc #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] low_i,
  input  logic [SW-1:0] high_i,
  output logic [SW-1:0] final_o
);

  logic [SW-1:0] span;
  logic [SW:0]   twice;
  logic [SW:0]   third;

  always_comb begin
    span    = high_i - low_i;
    twice   = {span, 1'b0};
    third   = twice / (SW+1)'(3);
    final_o = SW'({1'b0, low_i} + third);
  end

endmodule

// File: rtl/dqs_window_trainer.sv
`timescale 1ns/1ps
module dqs_window_trainer
  import dqscal_pkg::*;
#(
  parameter int            SW           = 8,
  parameter int            AW           = 32,
  parameter int            DW           = 32,
  parameter int            NWORDS       = 6,
  parameter int            STRIDE_SH    = 8,
  parameter logic [AW-1:0] LOW_BASE     = 'h4000,
  parameter logic [AW-1:0] HIGH_BASE    = 'h8000,
  parameter logic [DW-1:0] SEED         = 'h12345678,
  parameter logic [SW-1:0] DEFAULT_CODE = 'h59
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          dual_rank,
  input  logic [AW-1:0] rank_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [SW-1:0] dly_code,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [SW-1:0] low_bound,
  output logic [SW-1:0] high_bound,
  output logic [SW-1:0] final_setting
);

  localparam int              WIDX      = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [WIDX-1:0] LAST_WORD = WIDX'(NWORDS - 1);
  localparam logic [SW-1:0]   LAST_STEP = {{(SW-1){1'b1}}, 1'b0};
  localparam logic [SW-1:0]   TOP_STEP  = '1;

  state_t          st;
  phase_t          ph;
  logic [WIDX-1:0] word;
  logic [SW-1:0]   step;
  logic            hi_mode;

  logic [SW-1:0]   step_gray;
  logic [SW-1:0]   fin_bin;
  logic [SW-1:0]   fin_gray;
  logic [AW-1:0]   acc_addr;
  logic            acc_we;
  logic [DW-1:0]   acc_wdata;
  logic [DW-1:0]   acc_expect;
  logic            rd_miss;

  dqscal_gray #(.W(SW)) u_step_gray (
    .bin_i  (step),
    .gray_o (step_gray)
  );

  dqscal_window_calc #(.SW(SW)) u_calc (
    .low_i   (low_bound),
    .high_i  (high_bound),
    .final_o (fin_bin)
  );

  dqscal_gray #(.W(SW)) u_fin_gray (
    .bin_i  (fin_bin),
    .gray_o (fin_gray)
  );

  dqscal_access_gen #(
    .AW        (AW),
    .DW        (DW),
    .WIDX      (WIDX),
    .STRIDE_SH (STRIDE_SH),
    .LOW_BASE  (LOW_BASE),
    .HIGH_BASE (HIGH_BASE),
    .SEED      (SEED)
  ) u_acc (
    .phase_i     (ph),
    .word_i      (word),
    .hi_region_i (hi_mode),
    .dual_rank_i (dual_rank),
    .rank_base_i (rank_base),
    .addr_o      (acc_addr),
    .we_o        (acc_we),
    .wdata_o     (acc_wdata),
    .expect_o    (acc_expect)
  );

  assign rd_miss = !mem_we && (mem_rdata != acc_expect);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      ph            <= PH_CLR;
      word          <= '0;
      step          <= '0;
      hi_mode       <= 1'b0;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      dly_code      <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
      found         <= 1'b0;
      low_bound     <= '0;
      high_bound    <= '0;
      final_setting <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            found    <= 1'b0;
            step     <= '0;
            hi_mode  <= 1'b0;
            dly_code <= '0;
            st       <= ST_APPLY;
          end
        end

        ST_APPLY: begin
          dly_code <= step_gray;
          ph       <= PH_CLR;
          word     <= '0;
          st       <= ST_ISSUE;
        end

        ST_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= acc_we;
          mem_addr  <= acc_addr;
          mem_wdata <= acc_wdata;
          st        <= ST_WAIT;
        end

        ST_WAIT: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            if (rd_miss) begin
              // step failed
              if (hi_mode) begin
                high_bound <= step;
                st         <= ST_FINAL;
              end else if (step == LAST_STEP) begin
                dly_code      <= DEFAULT_CODE;
                final_setting <= DEFAULT_CODE;
                low_bound     <= TOP_STEP;
                high_bound    <= TOP_STEP;
                found         <= 1'b0;
                busy          <= 1'b0;
                done          <= 1'b1;
                st            <= ST_IDLE;
              end else begin
                step <= step + 1'b1;
                st   <= ST_APPLY;
              end
            end else if (word == LAST_WORD) begin
              word <= '0;
              case (ph)
                PH_CLR:  begin ph <= PH_FILL; st <= ST_ISSUE; end
                PH_FILL: begin ph <= PH_CHK;  st <= ST_ISSUE; end
                default: begin
                  // step passed
                  if (!hi_mode) begin
                    low_bound <= step;
                    hi_mode   <= 1'b1;
                  end
                  if (step == LAST_STEP) begin
                    high_bound <= TOP_STEP;
                    st         <= ST_FINAL;
                  end else begin
                    step <= step + 1'b1;
                    st   <= ST_APPLY;
                  end
                end
              endcase
            end else begin
              word <= word + 1'b1;
              st   <= ST_ISSUE;
            end
          end
        end

        ST_FINAL: begin
          dly_code      <= fin_gray;
          final_setting <= fin_bin;
          found         <= 1'b1;
          busy          <= 1'b0;
          done          <= 1'b1;
          st            <= ST_IDLE;
        end

        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dqs_window_trainer_chk.sv
`timescale 1ns/1ps
module dqs_window_trainer_chk #(
  parameter int            SW           = 8,
  parameter int            AW           = 32,
  parameter int            DW           = 32,
  parameter logic [SW-1:0] DEFAULT_CODE = 'h59
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          found,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [SW-1:0] dly_code,
  input logic [SW-1:0] low_bound,
  input logic [SW-1:0] high_bound,
  input logic [SW-1:0] final_setting
);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r9_req_drop: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

  a_r1_req_in_run: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r2_gray_step: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(dly_code)) |-> ($countones(dly_code ^ $past(dly_code)) == 1));

  a_r7_final_in_window: assert property (@(posedge clk) disable iff (rst)
    (done && found) |-> ((high_bound > low_bound) && (final_setting >= low_bound) && (final_setting < high_bound)));

  a_r8_fallback_code: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> ((dly_code == DEFAULT_CODE) && (final_setting == DEFAULT_CODE)));

endmodule

bind dqs_window_trainer dqs_window_trainer_chk #(
  .SW           (SW),
  .AW           (AW),
  .DW           (DW),
  .DEFAULT_CODE (DEFAULT_CODE)
) u_chk (.*);

// File: tb/dqs_window_trainer_tb.sv
`timescale 1ns/1ps
module dqs_window_trainer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dual_rank = 1'b0;
  logic [31:0] rank_base = 32'h0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  dly_code, low_bound, high_bound, final_setting;
  logic        busy, done, found;

  always #4 clk = ~clk;

  dqs_window_trainer u_dut (
    .clk (clk), .rst (rst), .start (start),
    .dual_rank (dual_rank), .rank_base (rank_base),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata),
    .dly_code (dly_code), .busy (busy), .done (done), .found (found),
    .low_bound (low_bound), .high_bound (high_bound), .final_setting (final_setting)
  );

  // R3 patterns
  localparam logic [31:0] PAT [0:5] = '{32'h12345678, 32'h81234567, 32'h78123456,
                                        32'h67812345, 32'h56781234, 32'h45678123};

  // {window low[31:24], window high excl[23:16], dual[15:8], latency[7:0]}
  localparam logic [31:0] VEC [0:6] = '{32'h0A28_0000, 32'h00FF_0000, 32'hFEFF_0001,
                                        32'h6465_0001, 32'hC8C8_0000, 32'h0509_0102,
                                        32'h0001_0103};

  int n_chk = 0, n_fail = 0;
  int cur_lo = 0, cur_hi = 0, cur_lat = 0;
  int acc_cnt = 0, addr_err = 0, data_err = 0, hs_err = 0, gray_err = 0;
  logic [31:0] mem [logic [31:0]];
  logic [7:0]  first_code;
  logic        first_seen;

  function automatic logic [7:0] gray_of(input int b);
    logic [7:0] v;
    v = 8'(b);
    return v ^ (v >> 1);
  endfunction

  function automatic int gray_dec(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return int'(b);
  endfunction

  function automatic int word_of(input logic [31:0] a);
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 6; k++)
        if (a == ((r == 0 ? 32'h4000 : 32'h8000) + 32'(k * 256) +
                  ((dual_rank && (k % 2 == 1)) ? rank_base : 32'h0)))
          return k;
    return -1;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    logic [31:0] a, d;
    logic        w;
    int          k, s;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !rst) begin
        a = mem_addr; w = mem_we; d = mem_wdata;
        repeat (cur_lat) begin
          @(negedge clk);
          if (!mem_req || mem_addr != a || mem_we != w || mem_wdata != d) hs_err++;
        end
        acc_cnt++;
        if (!first_seen) begin first_seen = 1'b1; first_code = dly_code; end
        k = word_of(a);
        if (k < 0) addr_err++;
        s = gray_dec(dly_code);
        if (w) begin
          if (k >= 0 && d != 32'h0 && d != PAT[k]) data_err++;
          mem[a] = d;
        end else begin
          mem_rdata = mem.exists(a) ? mem[a] : 32'h0;
          if (!(s >= cur_lo && s < cur_hi)) mem_rdata = mem_rdata ^ 32'h1;
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        if (mem_req && !rst) hs_err++;
      end
    end
  end

  // R2 monitor: sweep steps change one bit
  initial begin
    logic [7:0] prev;
    logic       pbusy;
    pbusy = 1'b0; prev = '0;
    forever begin
      @(negedge clk);
      if (pbusy && busy && dly_code != prev && $countones(dly_code ^ prev) != 1) gray_err++;
      pbusy = busy; prev = dly_code;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_vector(input logic [31:0] v);
    int lo, hi, lat, exp_low, exp_high, exp_fin, exp_cnt, waited;
    logic exp_found;
    logic [7:0] exp_code;
    lo = int'(v[31:24]); hi = int'(v[23:16]); lat = int'(v[7:0]);
    cur_lo = lo; cur_hi = hi; cur_lat = lat;
    dual_rank = v[8];
    rank_base = v[8] ? 32'h0010_0000 : 32'h0;
    acc_cnt = 0; addr_err = 0; data_err = 0; hs_err = 0; gray_err = 0;
    first_seen = 1'b0;
    mem.delete();
    exp_found = (lo < hi);
    exp_low   = exp_found ? lo : 255;
    exp_high  = exp_found ? hi : 255;
    exp_fin   = exp_found ? lo + ((hi - lo) * 2) / 3 : 'h59;
    exp_code  = exp_found ? gray_of(exp_fin) : 8'h59;
    exp_cnt   = exp_found ? (lo * 13 + (hi - lo) * 18 + ((hi <= 254) ? 13 : 0)) : 255 * 13;

    pulse_start();
    chk("R1", "busy after start", {31'h0, busy}, 32'h1);
    chk("R1", "done cleared by start", {31'h0, done}, 32'h0);
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;   // ignored (R1)
    waited = 0;
    while (!done && waited < 60000) begin @(negedge clk); waited++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual done=0 expected done=1");
    end
    chk("R1", "busy at done", {31'h0, busy}, 32'h0);
    chk("R5", "low_bound", {24'h0, low_bound}, 32'(exp_low));
    chk("R6", "high_bound", {24'h0, high_bound}, 32'(exp_high));
    chk(exp_found ? "R7" : "R8", "final_setting", {24'h0, final_setting}, 32'(exp_fin));
    chk(exp_found ? "R7" : "R8", "dly_code", {24'h0, dly_code}, {24'h0, exp_code});
    chk(exp_found ? "R7" : "R8", "found", {31'h0, found}, {31'h0, exp_found});
    chk("R3", "access count", 32'(acc_cnt), 32'(exp_cnt));
    chk("R3", "write data errors", 32'(data_err), 32'h0);
    chk("R4", "address errors", 32'(addr_err), 32'h0);
    chk("R9", "handshake errors", 32'(hs_err), 32'h0);
    chk("R2", "multi-bit sweep steps", 32'(gray_err), 32'h0);
    chk("R2", "first step code", {24'h0, first_code}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R1", "done held", {31'h0, done}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", {31'h0, busy}, 32'h0);
    chk("R1", "reset done", {31'h0, done}, 32'h0);
    chk("R1", "reset req", {31'h0, mem_req}, 32'h0);
    chk("R1", "reset dly_code", {24'h0, dly_code}, 32'h0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 7; i++) run_vector(VEC[i]);

    // reset in the middle of a run
    cur_lo = 0; cur_hi = 255; cur_lat = 0;
    pulse_start();
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "mid-run reset busy", {31'h0, busy}, 32'h0);
    chk("R1", "mid-run reset req", {31'h0, mem_req}, 32'h0);
    chk("R1", "mid-run reset dly_code", {24'h0, dly_code}, 32'h0);
    chk("R1", "mid-run reset found", {31'h0, found}, 32'h0);
    @(negedge clk); rst = 1'b0;
    repeat (4) @(negedge clk);
    run_vector(VEC[0]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule